// File: doc/BRIEF.md
# Home-Node Directory Controller with Busy-State Serialization

This block is the home side of an invalidation-based coherence protocol for a small shared-memory machine. For every memory block it keeps a directory entry. An entry holds one presence bit per node, a dirty flag and a busy flag. Requests come in one at a time on a valid/ready message port. The block looks up the entry for the addressed block, reads or writes the block's word through a single-word memory port when the protocol needs it, updates the entry, and sends at most one reply on a valid/ready reply port.

The protocol is strict request-response. When a block is dirty, the home does not fetch the data. It tells the requester which node owns the block, and the requester deals with that owner. A block that has an operation in flight is marked busy. Any read or exclusive read that reaches it is refused with a negative acknowledgement, which keeps writes to one block in a single order. Busy is cleared by the owner's revision message or by the exclusive requester's completion message.

Top module: `dirh_home_ctrl`

## Requirements
- R1: After reset, every entry is clean, not busy and has no presence bits set. `rsp_valid` and `mem_en` are low and `req_ready` is high.
- R2: A read (`req_kind`=0) of a block that is neither busy nor dirty returns a reply of kind 0 (data). The reply carries the memory word of that block and sets the requester's presence bit.
- R3: A read of a dirty, non-busy block returns a reply of kind 2 (owner), with no memory access, and marks the block busy.
- R4: A revision (`req_kind`=2) writes `req_data` to the block through the memory port, clears dirty and busy, and adds node `req_fwd` to the presence bits. A revision produces no reply.
- R5: An exclusive read (`req_kind`=1) of a clean, non-busy block returns a reply of kind 1. The reply carries the memory word and the presence vector with the requester's own bit cleared.
- R6: An exclusive read of a dirty, non-busy block returns an owner reply (kind 2) that names the current owner.
- R7: After any exclusive read that is not refused, only the requester's presence bit is set, the block is dirty with the requester as owner, and the block stays busy until a completion message (`req_kind`=4) arrives.
- R8: While a block is busy, a read or exclusive read to it gets a reply of kind 3 (negative acknowledgement) and leaves the entry unchanged.
- R9: A replacement hint (`req_kind`=3) from node k clears presence bit k and produces no reply.
- R10: `rsp_owner` is the index of the single set presence bit of the dirty block, encoded in clog2(NODES) bits.
- R11: Requests are taken one at a time. `req_ready` stays low from acceptance until the reply has been taken. While `rsp_ready` is low, the reply holds all its fields stable.
- R12: Revision, hint, completion and unknown kinds (5 to 7) produce no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 3 | 0 read, 1 exclusive read, 2 revision, 3 hint, 4 completion |
| req_src | input | clog2(NODES) | Sending node |
| req_blk | input | clog2(BLOCKS) | Addressed block |
| req_fwd | input | clog2(NODES) | For a revision: the node whose read caused it |
| req_data | input | DW | Block word carried by a revision |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply accepted |
| rsp_kind | output | 2 | 0 data, 1 exclusive data, 2 owner, 3 negative acknowledgement |
| rsp_dst | output | clog2(NODES) | Destination node (the requester) |
| rsp_owner | output | clog2(NODES) | Owner index for owner replies |
| rsp_sharers | output | NODES | Sharers to invalidate for exclusive data replies |
| rsp_data | output | DW | Block word for data replies |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | clog2(BLOCKS) | Memory block index |
| mem_wdata | output | DW | Memory write word |
| mem_rdata | input | DW | Memory read word, valid one cycle after a read |

## Verification
The bench builds the block with NODES=4, BLOCKS=8 and DW=16. With four nodes, every presence vector, including "all but the requester", and the highest owner index 3 can be driven and checked by hand. Eight blocks let each scenario (busy refusal, hints, self-only exclusive read, stalled reply) use a fresh entry. That way the reset state of each entry is also exercised.

// File: rtl/dirh_pkg.sv
package dirh_pkg;
   typedef enum logic [2:0] {
      MSG_READ   = 3'd0,
      MSG_RDEX   = 3'd1,
      MSG_REVISE = 3'd2,
      MSG_HINT   = 3'd3,
      MSG_DONE   = 3'd4
   } msg_e;

   typedef enum logic [1:0] {
      RPL_DATA   = 2'd0,
      RPL_DATAEX = 2'd1,
      RPL_OWNER  = 2'd2,
      RPL_NACK   = 2'd3
   } rpl_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_MEMW = 2'd2,
      ST_RESP = 2'd3
   } st_e;
endpackage

// File: rtl/dirh_entry_store.sv
module dirh_entry_store #(
   parameter int NODES  = 8,
   parameter int BLOCKS = 16,
   localparam int BW    = $clog2(BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BW-1:0]    rd_blk,
   output logic [NODES-1:0] rd_pres,
   output logic             rd_dirty,
   output logic             rd_busy,
   input  logic             wr_en,
   input  logic [BW-1:0]    wr_blk,
   input  logic [NODES-1:0] wr_pres,
   input  logic             wr_dirty,
   input  logic             wr_busy
);
   logic [NODES-1:0] pres_arr  [BLOCKS];
   logic             dirty_arr [BLOCKS];
   logic             busy_arr  [BLOCKS];

   for (genvar g = 0; g < BLOCKS; g++) begin : g_entry
      logic [NODES-1:0] pres_q;
      logic             dirty_q;
      logic             busy_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q  <= '0;
            dirty_q <= 1'b0;
            busy_q  <= 1'b0;
         end else if (wr_en && (wr_blk == BW'(g))) begin
            pres_q  <= wr_pres;
            dirty_q <= wr_dirty;
            busy_q  <= wr_busy;
         end
      end
      assign pres_arr[g]  = pres_q;
      assign dirty_arr[g] = dirty_q;
      assign busy_arr[g]  = busy_q;
   end

   assign rd_pres  = pres_arr[rd_blk];
   assign rd_dirty = dirty_arr[rd_blk];
   assign rd_busy  = busy_arr[rd_blk];
endmodule

// File: rtl/dirh_owner_enc.sv
module dirh_owner_enc #(
   parameter int NODES = 8,
   localparam int NW   = $clog2(NODES)
) (
   input  logic [NODES-1:0] vec,
   output logic [NW-1:0]    idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < NODES; i++) begin
         if (vec[i]) idx = NW'(i);
      end
   end
endmodule

// File: rtl/dirh_decide.sv
module dirh_decide
   import dirh_pkg::*;
#(
   parameter int NODES = 8,
   localparam int NW   = $clog2(NODES)
) (
   input  logic [2:0]       kind,
   input  logic [NW-1:0]    src,
   input  logic [NW-1:0]    fwd,
   input  logic [NODES-1:0] cur_pres,
   input  logic             cur_dirty,
   input  logic             cur_busy,
   output logic             upd,
   output logic [NODES-1:0] nxt_pres,
   output logic             nxt_dirty,
   output logic             nxt_busy,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             has_rsp,
   output logic [1:0]       rsp_kind,
   output logic [NODES-1:0] rsp_vec,
   output logic [NW-1:0]    owner
);
   localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

   logic [NODES-1:0] src_bit;
   logic [NODES-1:0] fwd_bit;

   assign src_bit = ONE << src;
   assign fwd_bit = ONE << fwd;

   dirh_owner_enc #(.NODES(NODES)) u_enc (
      .vec (cur_pres),
      .idx (owner)
   );

   always_comb begin
      upd       = 1'b0;
      nxt_pres  = cur_pres;
      nxt_dirty = cur_dirty;
      nxt_busy  = cur_busy;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      has_rsp   = 1'b0;
      rsp_kind  = RPL_NACK;
      rsp_vec   = '0;
      case (msg_e'(kind))
         MSG_READ: begin
            has_rsp = 1'b1;
            if (cur_busy) begin
               rsp_kind = RPL_NACK;
            end else if (cur_dirty) begin
               rsp_kind = RPL_OWNER;
               nxt_busy = 1'b1;
               upd      = 1'b1;
            end else begin
               rsp_kind = RPL_DATA;
               mem_rd   = 1'b1;
               nxt_pres = cur_pres | src_bit;
               upd      = 1'b1;
            end
         end
         MSG_RDEX: begin
            has_rsp = 1'b1;
            if (cur_busy) begin
               rsp_kind = RPL_NACK;
            end else begin
               if (cur_dirty) begin
                  rsp_kind = RPL_OWNER;
               end else begin
                  rsp_kind = RPL_DATAEX;
                  mem_rd   = 1'b1;
                  rsp_vec  = cur_pres & ~src_bit;
               end
               nxt_pres  = src_bit;
               nxt_dirty = 1'b1;
               nxt_busy  = 1'b1;
               upd       = 1'b1;
            end
         end
         MSG_REVISE: begin
            mem_wr    = 1'b1;
            nxt_pres  = cur_pres | fwd_bit;
            nxt_dirty = 1'b0;
            nxt_busy  = 1'b0;
            upd       = 1'b1;
         end
         MSG_HINT: begin
            nxt_pres = cur_pres & ~src_bit;
            upd      = 1'b1;
         end
         MSG_DONE: begin
            nxt_busy = 1'b0;
            upd      = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dirh_home_ctrl.sv
module dirh_home_ctrl
   import dirh_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int BLOCKS = 16,
   parameter int DW     = 32,
   localparam int NW    = $clog2(NODES),
   localparam int BW    = $clog2(BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_kind,
   input  logic [NW-1:0]    req_src,
   input  logic [BW-1:0]    req_blk,
   input  logic [NW-1:0]    req_fwd,
   input  logic [DW-1:0]    req_data,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [1:0]       rsp_kind,
   output logic [NW-1:0]    rsp_dst,
   output logic [NW-1:0]    rsp_owner,
   output logic [NODES-1:0] rsp_sharers,
   output logic [DW-1:0]    rsp_data,
   output logic             mem_en,
   output logic             mem_we,
   output logic [BW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata
);
   if (NODES < 2) begin : g_bad_nodes
      $error("dirh_home_ctrl: NODES must be at least 2");
   end
   if (BLOCKS < 2 || (1 << BW) != BLOCKS) begin : g_bad_blocks
      $error("dirh_home_ctrl: BLOCKS must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dirh_home_ctrl: DW must be positive");
   end

   st_e              state_q;
   logic [2:0]       kind_q;
   logic [NW-1:0]    src_q;
   logic [NW-1:0]    fwd_q;
   logic [BW-1:0]    blk_q;
   logic [DW-1:0]    data_q;

   logic [1:0]       o_kind_q;
   logic [NW-1:0]    o_owner_q;
   logic [NODES-1:0] o_vec_q;
   logic [DW-1:0]    o_data_q;

   logic [NODES-1:0] cur_pres;
   logic             cur_dirty, cur_busy;
   logic             upd, nxt_dirty, nxt_busy;
   logic [NODES-1:0] nxt_pres;
   logic             d_mem_rd, d_mem_wr, d_has_rsp;
   logic [1:0]       d_kind;
   logic [NODES-1:0] d_vec;
   logic [NW-1:0]    d_owner;
   logic             in_look;

   assign in_look = (state_q == ST_LOOK);

   dirh_entry_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_blk   (blk_q),
      .rd_pres  (cur_pres),
      .rd_dirty (cur_dirty),
      .rd_busy  (cur_busy),
      .wr_en    (in_look && upd),
      .wr_blk   (blk_q),
      .wr_pres  (nxt_pres),
      .wr_dirty (nxt_dirty),
      .wr_busy  (nxt_busy)
   );

   dirh_decide #(.NODES(NODES)) u_decide (
      .kind      (kind_q),
      .src       (src_q),
      .fwd       (fwd_q),
      .cur_pres  (cur_pres),
      .cur_dirty (cur_dirty),
      .cur_busy  (cur_busy),
      .upd       (upd),
      .nxt_pres  (nxt_pres),
      .nxt_dirty (nxt_dirty),
      .nxt_busy  (nxt_busy),
      .mem_rd    (d_mem_rd),
      .mem_wr    (d_mem_wr),
      .has_rsp   (d_has_rsp),
      .rsp_kind  (d_kind),
      .rsp_vec   (d_vec),
      .owner     (d_owner)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= '0;
         src_q     <= '0;
         fwd_q     <= '0;
         blk_q     <= '0;
         data_q    <= '0;
         o_kind_q  <= '0;
         o_owner_q <= '0;
         o_vec_q   <= '0;
         o_data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  kind_q  <= req_kind;
                  src_q   <= req_src;
                  fwd_q   <= req_fwd;
                  blk_q   <= req_blk;
                  data_q  <= req_data;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               o_kind_q  <= d_kind;
               o_owner_q <= d_owner;
               o_vec_q   <= d_vec;
               o_data_q  <= '0;
               if (!d_has_rsp)    state_q <= ST_IDLE;
               else if (d_mem_rd) state_q <= ST_MEMW;
               else               state_q <= ST_RESP;
            end
            ST_MEMW: begin
               o_data_q <= mem_rdata;
               state_q  <= ST_RESP;
            end
            ST_RESP: begin
               if (rsp_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign rsp_valid   = (state_q == ST_RESP);
   assign rsp_kind    = o_kind_q;
   assign rsp_dst     = src_q;
   assign rsp_owner   = o_owner_q;
   assign rsp_sharers = o_vec_q;
   assign rsp_data    = o_data_q;

   assign mem_en    = in_look && (d_mem_rd || d_mem_wr);
   assign mem_we    = in_look && d_mem_wr;
   assign mem_addr  = blk_q;
   assign mem_wdata = data_q;
endmodule

// File: rtl/dirh_home_ctrl_chk.sv
module dirh_home_ctrl_chk #(
   parameter int NODES  = 8,
   parameter int BLOCKS = 16,
   parameter int DW     = 32,
   localparam int NW    = $clog2(NODES),
   localparam int BW    = $clog2(BLOCKS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [1:0]       rsp_kind,
   input logic [NW-1:0]    rsp_dst,
   input logic [NW-1:0]    rsp_owner,
   input logic [NODES-1:0] rsp_sharers,
   input logic [DW-1:0]    rsp_data,
   input logic             mem_en,
   input logic             mem_we
);
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_dst) && $stable(rsp_owner) && $stable(rsp_sharers) && $stable(rsp_data)); // R11
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready); // R11
   AST_SHARERS_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == 2'd1 |-> rsp_sharers[rsp_dst] == 1'b0); // R5
   AST_WRITE_IS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_en); // R4
   AST_NO_MEM_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |-> !mem_en); // R11
endmodule

bind dirh_home_ctrl dirh_home_ctrl_chk #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
   .rsp_owner(rsp_owner), .rsp_sharers(rsp_sharers), .rsp_data(rsp_data),
   .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/dirh_home_ctrl_tb.sv
`timescale 1ns/1ps
module dirh_home_ctrl_tb_top;
   localparam int N  = 4;
   localparam int B  = 8;
   localparam int DW = 16;

   typedef struct {
      int          kind;
      int          dst;
      int          own;
      logic [N-1:0] vec;
      logic [DW-1:0] data;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [2:0] req_kind = '0;
   logic [1:0] req_src = '0;
   logic [2:0] req_blk = '0;
   logic [1:0] req_fwd = '0;
   logic [DW-1:0] req_data = '0;
   logic rsp_valid;
   logic rsp_ready = 1'b1;
   logic [1:0] rsp_kind;
   logic [1:0] rsp_dst;
   logic [1:0] rsp_owner;
   logic [N-1:0] rsp_sharers;
   logic [DW-1:0] rsp_data;
   logic mem_en, mem_we;
   logic [2:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   logic [DW-1:0] bmem  [B];
   logic [DW-1:0] shmem [B];
   logic [N-1:0]  mpres [B];
   bit            mdirty[B];
   bit            mbusy [B];
   int            mowner[B];

   exp_t q[$];
   int total = 0;
   int bad = 0;
   bit done_flag = 0;

   always #2.5 clk = ~clk;

   dirh_home_ctrl #(.NODES(N), .BLOCKS(B), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk), .req_fwd(req_fwd),
      .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_kind(rsp_kind), .rsp_dst(rsp_dst), .rsp_owner(rsp_owner),
      .rsp_sharers(rsp_sharers), .rsp_data(rsp_data), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) bmem[mem_addr] <= mem_wdata;
         else        mem_rdata <= bmem[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string tag, input string act, input string expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %s expected %s", tag, act, expv);
      end
   endtask

   // monitor: pops the scoreboard as replies are taken
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         if (q.size() == 0) begin
            chk(0, "R12 stray reply", $sformatf("kind=%0d dst=%0d", rsp_kind, rsp_dst), "no reply");
         end else begin
            exp_t e;
            bit ok;
            e = q.pop_front();
            ok = (int'(rsp_kind) == e.kind) && (int'(rsp_dst) == e.dst);
            if (e.kind == 2) ok = ok && (int'(rsp_owner) == e.own);
            if (e.kind == 0 || e.kind == 1) ok = ok && (rsp_data == e.data);
            if (e.kind == 1) ok = ok && (rsp_sharers == e.vec);
            chk(ok, e.tag,
                $sformatf("kind=%0d dst=%0d own=%0d vec=%b data=%h", rsp_kind, rsp_dst, rsp_owner, rsp_sharers, rsp_data),
                $sformatf("kind=%0d dst=%0d own=%0d vec=%b data=%h", e.kind, e.dst, e.own, e.vec, e.data));
         end
      end
   end

   task automatic push(input int k, input int dst, input int own, input logic [N-1:0] v,
                       input logic [DW-1:0] d, input string tag);
      exp_t e;
      e.kind = k; e.dst = dst; e.own = own; e.vec = v; e.data = d; e.tag = tag;
      q.push_back(e);
   endtask

   // driver: predicts from the requirements, then presents the request
   task automatic send(input int k, input int src, input int blk, input int fwd,
                       input logic [DW-1:0] d, input string tag);
      logic [N-1:0] sb;
      sb = N'(1) << src;
      case (k)
         0: if (mbusy[blk]) push(3, src, 0, '0, '0, tag);
            else if (mdirty[blk]) begin push(2, src, mowner[blk], '0, '0, tag); mbusy[blk] = 1; end
            else begin push(0, src, 0, '0, shmem[blk], tag); mpres[blk] |= sb; end
         1: if (mbusy[blk]) push(3, src, 0, '0, '0, tag);
            else begin
               if (mdirty[blk]) push(2, src, mowner[blk], '0, '0, tag);
               else push(1, src, 0, mpres[blk] & ~sb, shmem[blk], tag);
               mpres[blk] = sb; mdirty[blk] = 1; mowner[blk] = src; mbusy[blk] = 1;
            end
         2: begin shmem[blk] = d; mpres[blk] |= N'(1) << fwd; mdirty[blk] = 0; mbusy[blk] = 0; end
         3: mpres[blk] &= ~sb;
         4: mbusy[blk] = 0;
         default: ;
      endcase
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(k); req_src = 2'(src); req_blk = 3'(blk);
      req_fwd = 2'(fwd); req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
      while (q.size() != 0 || !req_ready) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         total++; bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < B; b++) begin
         bmem[b] = 16'hA000 + 16'(b); shmem[b] = 16'hA000 + 16'(b);
         mpres[b] = '0; mdirty[b] = 0; mbusy[b] = 0; mowner[b] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      chk(!rsp_valid && req_ready && !mem_en, "R1 reset outputs",
          $sformatf("v=%b rdy=%b men=%b", rsp_valid, req_ready, mem_en), "v=0 rdy=1 men=0");

      // R2 reads of a clean block, R1 fresh entry gives data
      send(0, 0, 1, 0, '0, "R2 read clean n0");
      send(0, 2, 1, 0, '0, "R2 read clean n2");
      send(0, 3, 1, 0, '0, "R2 read clean n3");
      // R5 exclusive read gives sharers without requester
      send(1, 2, 1, 0, '0, "R5 rdex clean sharers");
      // R8 busy block refuses
      send(0, 1, 1, 0, '0, "R8 nack read busy");
      send(1, 0, 1, 0, '0, "R8 nack rdex busy");
      // R7 completion clears busy; R3 owner reply
      send(4, 2, 1, 0, '0, "R7 done");
      send(0, 1, 1, 0, '0, "R3 read dirty owner");
      send(0, 3, 1, 0, '0, "R8 nack after owner reply");
      // R4 revision writes memory
      send(2, 2, 1, 1, 16'h5A5A, "R4 revise");
      drain();
      chk(bmem[1] == 16'h5A5A, "R4 memory written", $sformatf("%h", bmem[1]), "5a5a");
      send(0, 0, 1, 0, '0, "R4 read after revise");
      send(1, 3, 1, 0, '0, "R7 rdex vec after revise");
      send(4, 3, 1, 0, '0, "R7 done n3");
      // R6 and R10: exclusive read of dirty block names owner 3
      send(1, 0, 1, 0, '0, "R6 R10 rdex dirty owner");
      send(4, 0, 1, 0, '0, "R7 done n0");
      send(0, 2, 1, 0, '0, "R10 owner n0");
      send(2, 0, 1, 2, 16'h1234, "R4 revise 2");
      // R9 hint clears presence
      send(0, 1, 2, 0, '0, "R9 setup read n1");
      send(0, 3, 2, 0, '0, "R9 setup read n3");
      send(3, 1, 2, 0, '0, "R9 hint n1");
      send(1, 0, 2, 0, '0, "R9 rdex after hint");
      send(4, 0, 2, 0, '0, "R7 done blk2");
      // R5 self-only sharer gives empty vector
      send(0, 2, 4, 0, '0, "R5 setup read n2");
      send(1, 2, 4, 0, '0, "R5 rdex self only");
      send(4, 2, 4, 0, '0, "R7 done blk4");
      // R10 highest owner index
      send(1, 3, 5, 0, '0, "R10 setup rdex n3");
      send(4, 3, 5, 0, '0, "R7 done blk5");
      send(0, 1, 5, 0, '0, "R10 owner index 3");
      drain();

      // R11 stalled reply holds and blocks new requests
      rsp_ready = 1'b0;
      send(0, 0, 3, 0, '0, "R11 stalled read");
      while (!rsp_valid) @(negedge clk);
      begin
         logic [DW-1:0] d0;
         d0 = rsp_data;
         repeat (3) @(negedge clk);
         chk(rsp_valid && !req_ready && rsp_data == d0 && rsp_kind == 2'd0,
             "R11 reply held", $sformatf("v=%b rdy=%b data=%h", rsp_valid, req_ready, rsp_data),
             $sformatf("v=1 rdy=0 data=%h", d0));
      end
      rsp_ready = 1'b1;
      drain();

      // R12 unknown kind gives no reply, entry untouched
      send(7, 1, 6, 0, '0, "R12 unknown kind");
      repeat (6) @(negedge clk);
      chk(!rsp_valid && req_ready, "R12 no reply to unknown",
          $sformatf("v=%b", rsp_valid), "v=0");
      send(0, 1, 6, 0, '0, "R12 entry untouched after unknown");
      drain();

      chk(q.size() == 0, "R11 all replies seen", $sformatf("%0d left", q.size()), "0 left");
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule